// File: doc/BRIEF.md
# Pulse Dial and Flash Generator

This block turns dialing commands into loop-disconnect activity on a telephone line interface. A digit command opens the line loop once for each count of the digit, at 10 or 20 pulses per second, with a selectable make/break ratio. A short pre-digit pause comes before the first break, and an inter-digit pause follows the last one. A flash command opens the loop for one of four fixed break times and then waits a fixed flash pause. A pause command holds the line idle for a long fixed time. Two mute outputs follow the sequence so that the speech path and the handset can be silenced while the loop is opened.

All timing is counted in units of one third of a millisecond. A prescaler divides a base strobe, `tick_i`, to produce one unit every `PRESCALE` strobes. Commands come in on single-cycle strobes. A one-entry buffer holds a command that arrives while the block is busy. When a command arrives and the buffer cannot take it, the command is lost and a sticky overflow flag is set.

Top module: `pulse_dialer`

## Requirements
- R1: A digit strobe with code 1 to 9 gives that many breaks. Codes 0 and 10 give ten breaks. Codes 11 to 15 are dropped: no output, and busy stays low.
- R2: With rate_sel_i=0 the pulse period is 300 units, and with rate_sel_i=1 it is 150 units. With ratio_sel_i=0 the make part is 2/5 of the period and the break part 3/5. With ratio_sel_i=1 the make part is 1/3 and the break part 2/3.
- R3: The first break comes after a pre-digit pause equal to one make time. After the last break there is an inter-digit pause of 2400 units (rate 0) or 1500 units (rate 1), and then the block goes idle.
- R4: A pause strobe keeps busy_o high for 10800 units. During that time dp_break_o, dial_mute_o and hp_mute_o all stay low.
- R5: A flash strobe drives dp_break_o high for 1800, 900, 219 or 300 units, for flash_sel_i equal to 0, 1, 2 or 3. A 3000-unit flash pause follows, with all line outputs low, and then the block goes idle.
- R6: For a digit, dial_mute_o rises when the first break starts and falls when the inter-digit pause ends. It stays low for flash and pause commands.
- R7: hp_mute_o is high during a digit's pre-digit pause, its breaks and its makes, and during a flash break. It is low at all other times.
- R8: busy_o rises in the cycle after the accepting edge. It stays high until the sequence, including its trailing pause, has ended. While busy_o is low, all line outputs are low.
- R9: A command that arrives while the block is busy and the buffer is empty is buffered. It starts after the current sequence ends, with one idle cycle between the two. A command that arrives while the buffer is full and not being emptied is dropped and sets ovf_o. ovf_o stays high until reset.
- R10: When strobes arrive in the same cycle, only one command is taken. A flash wins over a digit, and a digit wins over a pause.
- R11: Rate and ratio are captured when the command is accepted. Changing them afterwards does not affect that command.
- R12: Reset clears every output to low, including ovf_o. This holds even in the middle of a sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | Base time strobe, divided by PRESCALE into 1/3 ms units |
| digit_i | input | 4 | Digit code |
| digit_vld_i | input | 1 | Digit strobe |
| rate_sel_i | input | 1 | 0: 10 pps, 1: 20 pps |
| ratio_sel_i | input | 1 | 0: 40:60 make/break, 1: 1:2 make/break |
| flash_req_i | input | 1 | Flash strobe |
| flash_sel_i | input | 2 | Flash break length select |
| pause_req_i | input | 1 | Pause strobe |
| dp_break_o | output | 1 | High while the line loop is opened |
| dial_mute_o | output | 1 | Speech-path mute for the pulse train |
| hp_mute_o | output | 1 | Handset mute during breaks and makes |
| busy_o | output | 1 | Command buffered or sequence running |
| ovf_o | output | 1 | Sticky: a command was dropped |

## Verification
The assertions check four properties on every cycle:
- all line outputs are quiet whenever busy is low;
- the overflow flag sets when a command is dropped, and stays set afterwards;
- only a final break is followed by the inter-digit pause;
- a flash break always passes into the flash pause.

The bench scenarios are needed for the things a single-cycle property cannot show. These are the break counts, the exact lengths of make, break and pause intervals for each rate, ratio and flash selector, the strobe priority, the capture of the modes at acceptance, and the timing of a buffered command that starts after an earlier one.

// File: rtl/dpf_pkg.sv
package dpf_pkg;

    typedef enum logic [1:0] {
        CMD_DIGIT = 2'd0,
        CMD_PAUSE = 2'd1,
        CMD_FLASH = 2'd2
    } cmd_kind_e;

    typedef struct packed {
        cmd_kind_e  kind;
        logic [3:0] breaks;
        logic       rate;
        logic       ratio;
        logic [1:0] fsel;
    } cmd_t;

    typedef enum logic [2:0] {
        S_IDLE  = 3'd0,
        S_PRE   = 3'd1,
        S_BRK   = 3'd2,
        S_MAK   = 3'd3,
        S_IDP   = 3'd4,
        S_PAUSE = 3'd5,
        S_FBRK  = 3'd6,
        S_FPAU  = 3'd7
    } seq_state_e;

    function automatic int max2(int a, int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/dpf_cmd_queue.sv
module dpf_cmd_queue
    import dpf_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic push_i,
    input  cmd_t cmd_i,
    input  logic pop_i,
    output logic full_o,
    output cmd_t cmd_o,
    output logic ovf_o
);

    typedef struct packed {
        logic full;
        cmd_t cmd;
        logic ovf;
    } q_regs_t;

    q_regs_t q_q, q_d;

    always_comb begin
        q_d = q_q;
        if (pop_i) begin
            q_d.full = 1'b0;
        end
        if (push_i) begin
            if (!q_q.full || pop_i) begin
                q_d.full = 1'b1;
                q_d.cmd  = cmd_i;
            end else begin
                q_d.ovf = 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            q_q <= '0;
        end else begin
            q_q <= q_d;
        end
    end

    assign full_o = q_q.full;
    assign cmd_o  = q_q.cmd;
    assign ovf_o  = q_q.ovf;

    // R9
    drop_sets_ovf_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (push_i && q_q.full && !pop_i) |=> q_q.ovf);

    // R9
    ovf_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        q_q.ovf |=> q_q.ovf);

endmodule

// File: rtl/dpf_seq.sv
module dpf_seq
    import dpf_pkg::*;
#(
    parameter int CNT_W           = 14,
    parameter int PERIOD_SLOW     = 300,
    parameter int IDP_SLOW        = 2400,
    parameter int IDP_FAST        = 1500,
    parameter int PAUSE_LEN       = 10800,
    parameter int FLASH_PAUSE_LEN = 3000,
    parameter int FLASH_LEN0      = 1800,
    parameter int FLASH_LEN1      = 900,
    parameter int FLASH_LEN2      = 219,
    parameter int FLASH_LEN3      = 300
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic unit_tick_i,
    input  logic cmd_vld_i,
    input  cmd_t cmd_i,
    output logic pop_o,
    output logic active_o,
    output logic dp_break_o,
    output logic dial_mute_o,
    output logic hp_mute_o
);

    localparam int PERIOD_FAST = PERIOD_SLOW / 2;

    typedef struct packed {
        seq_state_e       state;
        logic [CNT_W-1:0] cnt;
        logic [3:0]       rem;
        logic             rate;
        logic             ratio;
    } seq_regs_t;

    seq_regs_t s_q, s_d;

    function automatic int period_of(logic rate);
        return rate ? PERIOD_FAST : PERIOD_SLOW;
    endfunction

    function automatic logic [CNT_W-1:0] make_last(logic rate, logic ratio);
        int p;
        p = period_of(rate);
        return CNT_W'((ratio ? (p / 3) : ((p * 2) / 5)) - 1);
    endfunction

    function automatic logic [CNT_W-1:0] brk_last(logic rate, logic ratio);
        int p;
        p = period_of(rate);
        return CNT_W'((p - (ratio ? (p / 3) : ((p * 2) / 5))) - 1);
    endfunction

    function automatic logic [CNT_W-1:0] flash_last(logic [1:0] sel);
        case (sel)
            2'd0:    return CNT_W'(FLASH_LEN0 - 1);
            2'd1:    return CNT_W'(FLASH_LEN1 - 1);
            2'd2:    return CNT_W'(FLASH_LEN2 - 1);
            default: return CNT_W'(FLASH_LEN3 - 1);
        endcase
    endfunction

    always_comb begin
        s_d   = s_q;
        pop_o = 1'b0;
        if (s_q.state == S_IDLE) begin
            if (cmd_vld_i) begin
                pop_o   = 1'b1;
                s_d.rate  = cmd_i.rate;
                s_d.ratio = cmd_i.ratio;
                s_d.rem   = cmd_i.breaks;
                case (cmd_i.kind)
                    CMD_DIGIT: begin
                        s_d.state = S_PRE;
                        s_d.cnt   = make_last(cmd_i.rate, cmd_i.ratio);
                    end
                    CMD_FLASH: begin
                        s_d.state = S_FBRK;
                        s_d.cnt   = flash_last(cmd_i.fsel);
                    end
                    default: begin
                        s_d.state = S_PAUSE;
                        s_d.cnt   = CNT_W'(PAUSE_LEN - 1);
                    end
                endcase
            end
        end else if (unit_tick_i) begin
            if (s_q.cnt != '0) begin
                s_d.cnt = s_q.cnt - 1'b1;
            end else begin
                case (s_q.state)
                    S_PRE, S_MAK: begin
                        s_d.state = S_BRK;
                        s_d.cnt   = brk_last(s_q.rate, s_q.ratio);
                    end
                    S_BRK: begin
                        if (s_q.rem > 4'd1) begin
                            s_d.rem   = s_q.rem - 4'd1;
                            s_d.state = S_MAK;
                            s_d.cnt   = make_last(s_q.rate, s_q.ratio);
                        end else begin
                            s_d.state = S_IDP;
                            s_d.cnt   = CNT_W'((s_q.rate ? IDP_FAST : IDP_SLOW) - 1);
                        end
                    end
                    S_FBRK: begin
                        s_d.state = S_FPAU;
                        s_d.cnt   = CNT_W'(FLASH_PAUSE_LEN - 1);
                    end
                    default: begin
                        s_d.state = S_IDLE;
                    end
                endcase
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign active_o    = (s_q.state != S_IDLE);
    assign dp_break_o  = (s_q.state == S_BRK) || (s_q.state == S_FBRK);
    assign dial_mute_o = (s_q.state == S_BRK) || (s_q.state == S_MAK) || (s_q.state == S_IDP);
    assign hp_mute_o   = (s_q.state == S_PRE) || (s_q.state == S_BRK) ||
                         (s_q.state == S_MAK) || (s_q.state == S_FBRK);

    // R1
    break_count_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (s_q.state == S_PRE || s_q.state == S_BRK || s_q.state == S_MAK)
            |-> (s_q.rem >= 4'd1 && s_q.rem <= 4'd10));

    // R3
    last_break_to_idp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (s_q.state == S_IDP && $past(s_q.state) == S_BRK) |-> ($past(s_q.rem) == 4'd1));

    // R5
    flash_to_pause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(s_q.state) == S_FBRK && s_q.state != S_FBRK) |-> (s_q.state == S_FPAU));

    // R6
    dial_mute_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(dial_mute_o) |-> (s_q.state == S_IDLE));

endmodule

// File: rtl/pulse_dialer.sv
module pulse_dialer
    import dpf_pkg::*;
#(
    parameter int PRESCALE        = 1,
    parameter int PERIOD_SLOW     = 300,
    parameter int IDP_SLOW        = 2400,
    parameter int IDP_FAST        = 1500,
    parameter int PAUSE_LEN       = 10800,
    parameter int FLASH_PAUSE_LEN = 3000,
    parameter int FLASH_LEN0      = 1800,
    parameter int FLASH_LEN1      = 900,
    parameter int FLASH_LEN2      = 219,
    parameter int FLASH_LEN3      = 300
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       tick_i,
    input  logic [3:0] digit_i,
    input  logic       digit_vld_i,
    input  logic       rate_sel_i,
    input  logic       ratio_sel_i,
    input  logic       flash_req_i,
    input  logic [1:0] flash_sel_i,
    input  logic       pause_req_i,
    output logic       dp_break_o,
    output logic       dial_mute_o,
    output logic       hp_mute_o,
    output logic       busy_o,
    output logic       ovf_o
);

    localparam int LONGEST = max2(PAUSE_LEN, max2(FLASH_PAUSE_LEN,
                             max2(IDP_SLOW, max2(FLASH_LEN0, PERIOD_SLOW))));
    localparam int CNT_W   = $clog2(LONGEST + 1);
    localparam int PRE_W   = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;

    typedef struct packed {
        logic [PRE_W-1:0] pre;
    } top_regs_t;

    top_regs_t t_q, t_d;
    logic      unit_tick;
    logic      push;
    cmd_t      new_cmd;
    logic      q_full;
    cmd_t      q_cmd;
    logic      pop;
    logic      seq_active;

    always_comb begin
        t_d       = t_q;
        unit_tick = 1'b0;
        if (tick_i) begin
            if (t_q.pre == PRE_W'(PRESCALE - 1)) begin
                unit_tick = 1'b1;
                t_d.pre   = '0;
            end else begin
                t_d.pre = t_q.pre + 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            t_q <= '0;
        end else begin
            t_q <= t_d;
        end
    end

    // strobe decode with flash > digit > pause priority
    always_comb begin
        push          = 1'b0;
        new_cmd       = '0;
        new_cmd.rate  = rate_sel_i;
        new_cmd.ratio = ratio_sel_i;
        new_cmd.fsel  = flash_sel_i;
        if (flash_req_i) begin
            push         = 1'b1;
            new_cmd.kind = CMD_FLASH;
        end else if (digit_vld_i && digit_i <= 4'd10) begin
            push           = 1'b1;
            new_cmd.kind   = CMD_DIGIT;
            new_cmd.breaks = (digit_i == 4'd0) ? 4'd10 : digit_i;
        end else if (pause_req_i) begin
            push         = 1'b1;
            new_cmd.kind = CMD_PAUSE;
        end
    end

    dpf_cmd_queue u_queue (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .push_i (push),
        .cmd_i  (new_cmd),
        .pop_i  (pop),
        .full_o (q_full),
        .cmd_o  (q_cmd),
        .ovf_o  (ovf_o)
    );

    dpf_seq #(
        .CNT_W           (CNT_W),
        .PERIOD_SLOW     (PERIOD_SLOW),
        .IDP_SLOW        (IDP_SLOW),
        .IDP_FAST        (IDP_FAST),
        .PAUSE_LEN       (PAUSE_LEN),
        .FLASH_PAUSE_LEN (FLASH_PAUSE_LEN),
        .FLASH_LEN0      (FLASH_LEN0),
        .FLASH_LEN1      (FLASH_LEN1),
        .FLASH_LEN2      (FLASH_LEN2),
        .FLASH_LEN3      (FLASH_LEN3)
    ) u_seq (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .unit_tick_i (unit_tick),
        .cmd_vld_i   (q_full),
        .cmd_i       (q_cmd),
        .pop_o       (pop),
        .active_o    (seq_active),
        .dp_break_o  (dp_break_o),
        .dial_mute_o (dial_mute_o),
        .hp_mute_o   (hp_mute_o)
    );

    assign busy_o = q_full | seq_active;

    // R8
    idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !busy_o |-> (!dp_break_o && !dial_mute_o && !hp_mute_o));

endmodule

// File: tb/pulse_dialer_test.sv
module pulse_dialer_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b1;
    logic [3:0] digit = '0;
    logic       digit_vld = 1'b0;
    logic       rate_sel = 1'b0;
    logic       ratio_sel = 1'b0;
    logic       flash_req = 1'b0;
    logic [1:0] flash_sel = '0;
    logic       pause_req = 1'b0;
    logic       dp_break, dial_mute, hp_mute, busy, ovf;

    always #2.5 clk = ~clk;

    pulse_dialer uut (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .tick_i      (tick),
        .digit_i     (digit),
        .digit_vld_i (digit_vld),
        .rate_sel_i  (rate_sel),
        .ratio_sel_i (ratio_sel),
        .flash_req_i (flash_req),
        .flash_sel_i (flash_sel),
        .pause_req_i (pause_req),
        .dp_break_o  (dp_break),
        .dial_mute_o (dial_mute),
        .hp_mute_o   (hp_mute),
        .busy_o      (busy),
        .ovf_o       (ovf)
    );

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;

    // measurement accumulators
    int m_busy, m_rises, m_first, m_pre, m_hp, m_mute;
    logic m_prev_dp, m_last_busy;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles == 190000) begin
            n_fail = n_fail + 1;
            $display("FAIL watchdog: actual %0d cycles, expected fewer", cycles);
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    task automatic check(string tag, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic clr_meas();
        m_busy = 0; m_rises = 0; m_first = 0; m_pre = 0; m_hp = 0; m_mute = 0;
        m_prev_dp = 1'b0; m_last_busy = 1'b0;
    endtask

    task automatic sample();
        @(negedge clk);
        if (busy) m_busy++;
        if (dp_break && !m_prev_dp) m_rises++;
        if (dp_break && m_rises == 1) m_first++;
        if (busy && !dp_break && m_rises == 0) m_pre++;
        if (hp_mute) m_hp++;
        if (dial_mute) m_mute++;
        m_prev_dp   = dp_break;
        m_last_busy = busy;
    endtask

    task automatic clear_strobes();
        digit_vld = 1'b0; flash_req = 1'b0; pause_req = 1'b0;
    endtask

    task automatic drain();
        for (int i = 0; i < 20000 && m_last_busy; i++) sample();
    endtask

    // expected timing computed from R2 / R3 / R5
    function automatic int e_period(int rate);
        return rate ? 150 : 300;
    endfunction
    function automatic int e_make(int rate, int ratio);
        return ratio ? e_period(rate) / 3 : (e_period(rate) * 2) / 5;
    endfunction
    function automatic int e_idp(int rate);
        return rate ? 1500 : 2400;
    endfunction
    function automatic int e_flash(int sel);
        case (sel)
            0: return 1800;
            1: return 900;
            2: return 219;
            default: return 300;
        endcase
    endfunction

    typedef struct packed {
        int kind;    // 0 digit, 1 pause, 2 flash
        int code;
        int rate;
        int ratio;
        int fsel;
        int breaks;
        int busy_cycles;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VECS [NV] = '{
        '{0,  1, 0, 0, 0,  1,  2701},
        '{0,  3, 1, 1, 0,  3,  1951},
        '{0,  0, 1, 0, 0, 10,  3001},
        '{0,  9, 0, 1, 0,  9,  5101},
        '{0, 10, 1, 1, 0, 10,  3001},
        '{2,  0, 0, 0, 0,  1,  4801},
        '{2,  0, 0, 0, 2,  1,  3220},
        '{2,  0, 0, 0, 3,  1,  3301},
        '{2,  0, 0, 0, 1,  1,  3901},
        '{1,  0, 0, 0, 0,  0, 10801},
        '{0, 12, 0, 0, 0,  0,     0}
    };

    initial begin
        clr_meas();
        repeat (4) @(negedge clk);
        // R12: reset state
        check("R12 reset dp_break", int'(dp_break), 0);
        check("R12 reset busy", int'(busy), 0);
        check("R12 reset mutes", int'(dial_mute | hp_mute), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        for (int v = 0; v < NV; v++) begin
            vec_t t;
            int p, mk, n;
            t = VECS[v];
            clr_meas();
            rate_sel  = t.rate[0];
            ratio_sel = t.ratio[0];
            flash_sel = t.fsel[1:0];
            digit     = t.code[3:0];
            digit_vld = (t.kind == 0);
            pause_req = (t.kind == 1);
            flash_req = (t.kind == 2);
            sample();
            clear_strobes();
            drain();
            n  = t.breaks;
            p  = e_period(t.rate);
            mk = e_make(t.rate, t.ratio);
            if (t.kind == 0) begin
                check($sformatf("R1 vec%0d break count", v), m_rises, n);
                check($sformatf("R8 vec%0d busy length", v), m_busy, t.busy_cycles);
                if (n > 0) begin
                    check($sformatf("R2 vec%0d break length", v), m_first, p - mk);
                    check($sformatf("R3 vec%0d predigit", v), m_pre, mk + 1);
                    check($sformatf("R7 vec%0d hp_mute cycles", v), m_hp, n * p);
                    check($sformatf("R6 vec%0d dial_mute cycles", v), m_mute,
                          n * p - mk + e_idp(t.rate));
                end
            end else if (t.kind == 2) begin
                check($sformatf("R5 vec%0d flash breaks", v), m_rises, 1);
                check($sformatf("R5 vec%0d flash length", v), m_first, e_flash(t.fsel));
                check($sformatf("R5 vec%0d flash busy", v), m_busy, e_flash(t.fsel) + 3000 + 1);
                check($sformatf("R7 vec%0d flash hp_mute", v), m_hp, e_flash(t.fsel));
                check($sformatf("R6 vec%0d flash dial_mute", v), m_mute, 0);
            end else begin
                check($sformatf("R4 vec%0d pause busy", v), m_busy, t.busy_cycles);
                check($sformatf("R4 vec%0d pause line quiet", v), m_rises + m_hp + m_mute, 0);
            end
            repeat (2) @(negedge clk);
        end
        check("R9 no overflow after table", int'(ovf), 0);

        // R10: simultaneous strobes, flash wins
        clr_meas();
        flash_sel = 2'd0; digit = 4'd5; rate_sel = 1'b0; ratio_sel = 1'b0;
        flash_req = 1'b1; digit_vld = 1'b1; pause_req = 1'b1;
        sample();
        clear_strobes();
        drain();
        check("R10 priority breaks", m_rises, 1);
        check("R10 priority flash length", m_first, 1800);
        check("R10 priority busy", m_busy, 4801);
        repeat (2) @(negedge clk);

        // R11: modes captured at acceptance
        clr_meas();
        digit = 4'd2; rate_sel = 1'b1; ratio_sel = 1'b1; digit_vld = 1'b1;
        sample();
        clear_strobes();
        rate_sel = 1'b0; ratio_sel = 1'b0;
        drain();
        check("R11 latched break length", m_first, 100);
        check("R11 latched predigit", m_pre, 51);
        check("R11 latched busy", m_busy, 1801);
        repeat (2) @(negedge clk);

        // R9: one buffered command, the next dropped
        clr_meas();
        rate_sel = 1'b0; ratio_sel = 1'b0;
        digit = 4'd1; digit_vld = 1'b1;
        sample();
        clear_strobes();
        repeat (10) sample();
        digit = 4'd2; digit_vld = 1'b1;
        sample();
        clear_strobes();
        check("R9 buffered command no overflow", int'(ovf), 0);
        digit = 4'd3; digit_vld = 1'b1;
        sample();
        clear_strobes();
        check("R9 overflow flagged", int'(ovf), 1);
        drain();
        check("R9 breaks of first plus buffered", m_rises, 3);
        check("R9 back-to-back busy", m_busy, 5702);
        check("R9 overflow sticky", int'(ovf), 1);
        repeat (2) @(negedge clk);

        // R12: reset in the middle of a digit
        digit = 4'd5; digit_vld = 1'b1;
        @(negedge clk);
        clear_strobes();
        repeat (200) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R12 mid-sequence reset busy", int'(busy), 0);
        check("R12 mid-sequence reset line", int'(dp_break | hp_mute | dial_mute), 0);
        check("R12 reset clears overflow", int'(ovf), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule